// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Per-Source Trigger Control

This block gathers up to 96 interrupt lines into two processor request outputs: a normal request and a fast request. It is built from three 32-source slices. The main slice drives the two outputs. Two subordinate slices feed their own normal and fast requests into four fixed main-slice inputs. Each source can be set to sense a level or an edge, can be made active-high or active-low, and can be steered to either output. Raw pending state can be read whether or not the source is enabled. Edge captures stay pending until software clears them.

All slice registers are written and read over one flat register port. Address bits [15:14] select the slice, or the software-interrupt word when they are 3. Bits [4:2] select a register inside that slice. The block also reports, in registered form, the global number of the highest-numbered pending normal-request source. It searches the main slice first, then the first subordinate slice, then the second. A dispatch routine can use this number directly as its vector.

Top module: `vic_cascade_top`

## Requirements
- R1: A write takes effect only when wr_addr[1:0] and wr_addr[13:5] are zero. Bits [15:14] select main (0), sub-A (1), sub-B (2) or software word (3). Bits [4:2] select the register: 0 enable, 1 raw status, 2 enabled status, 3 polarity, 4 trigger type, 5 route. Reads follow the same decode and appear on rd_data one clock after rd_addr is presented.
- R2: Reset clears every register and output to 0, with one exception: the main enable register resets to 0xC0000003.
- R3: For a level source, the raw status bit follows the synchronised input when its polarity bit is 1, and the inverted input when its polarity bit is 0.
- R4: A source whose trigger-type bit is 1 latches into raw status on the active edge: rising when its polarity bit is 1, falling when it is 0. It stays set after the input returns. Writing 1 to that raw-status bit clears it; writing 0 leaves it unchanged.
- R5: Enabled status equals raw status AND enable. Raw status shows a pending source even while it is disabled.
- R6: irq_o is the registered OR of the main slice's enabled-status bits whose route bit is 0. fiq_o is the same for route bit 1.
- R7: Main bit 0 carries sub-A's normal request, bit 1 sub-B's normal request, bit 30 sub-A's fast request, and bit 31 sub-B's fast request. The external lines for those four bits are ignored. These four bits always act as level, active-high, whatever their polarity and type bits hold.
- R8: pend_idx_o is the global number (slice×32 + bit) of the highest-numbered enabled source that is routed to the normal request. The main slice is searched first (excluding bits 0, 1, 30 and 31), then sub-A, then sub-B. pend_valid_o flags a hit, and pend_idx_o is 0 when there is none.
- R9: Writing 1 to bit 0 of the software word raises global source 33 (sub-A bit 1), ORed with that input after synchronisation. Writing 0 lowers it. The word reads back its value.
- R10: Writes to the enabled-status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 96 | Asynchronous interrupt lines, global numbering |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| pend_valid_o | output | 1 | A normal-routed enabled source is pending |
| pend_idx_o | output | 7 | Global number of the selected pending source |

## Verification
Two functions can fall in the same cycle: the pending-source search on the main slice, and a pending request arriving from a subordinate slice. The bench keeps a sub-B source pending, then enables a main source that is already active. It judges the result by whether pend_idx_o moves from the sub-B number to the main bit while irq_o stays high. A second overlap is provoked by routing a sub-B source to the fast output while the same main cascade bit is switched between routes. Here fiq_o and irq_o must swap, while the search still reports nothing.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [2:0] {
    OFF_EN    = 3'd0,
    OFF_RAW   = 3'd1,
    OFF_STAT  = 3'd2,
    OFF_POL   = 3'd3,
    OFF_TYPE  = 3'd4,
    OFF_ROUTE = 3'd5
  } reg_sel_e;

  localparam int REG_LSB = 2;
  localparam int REG_AW  = 3;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vic_prio_find.sv
module vic_prio_find #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_slice.sv
module vic_slice
  import vic_pkg::*;
#(
  parameter int           W      = 32,
  parameter logic [W-1:0] RST_EN = '0,
  parameter logic [W-1:0] BYPASS = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [W-1:0] wr_data,
  input  reg_sel_e     rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] cand_o,
  output logic         irq_o,
  output logic         fiq_o
);
  logic [W-1:0] en_q, raw_q, pol_q, typ_q, route_q, src_d;
  logic [W-1:0] lvl_val, edge_hit, is_edge, clr_mask, raw_nxt, stat;

  // active level per source; cascade bits are taken as active-high levels
  assign lvl_val  = (BYPASS & src_i) | (~BYPASS & ~(src_i ^ pol_q));
  assign edge_hit = (src_i & ~src_d & pol_q) | (~src_i & src_d & ~pol_q);
  assign is_edge  = typ_q & ~BYPASS;
  assign clr_mask = (wr_en && wr_sel == OFF_RAW) ? wr_data : '0;
  assign raw_nxt  = (is_edge & ((raw_q & ~clr_mask) | edge_hit)) |
                    (~is_edge & lvl_val);
  assign stat     = raw_q & en_q;
  assign cand_o   = stat & ~route_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= RST_EN;
      raw_q   <= '0;
      pol_q   <= '0;
      typ_q   <= '0;
      route_q <= '0;
      src_d   <= '0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      src_d <= src_i;
      raw_q <= raw_nxt;
      irq_o <= |(stat & ~route_q);
      fiq_o <= |(stat & route_q);
      if (wr_en) begin
        case (wr_sel)
          OFF_EN:    en_q    <= wr_data;
          OFF_POL:   pol_q   <= wr_data;
          OFF_TYPE:  typ_q   <= wr_data;
          OFF_ROUTE: route_q <= wr_data;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel)
      OFF_EN:    rd_data = en_q;
      OFF_RAW:   rd_data = raw_q;
      OFF_STAT:  rd_data = stat;
      OFF_POL:   rd_data = pol_q;
      OFF_TYPE:  rd_data = typ_q;
      OFF_ROUTE: rd_data = route_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/vic_cascade_top.sv
module vic_cascade_top
  import vic_pkg::*;
#(
  parameter int SLICE_W   = 32,
  parameter int ADDR_W    = 16,
  parameter int MOD_SHIFT = 14,
  parameter int SYNC_LEN  = 2,
  parameter int SW_SRC    = 33,
  localparam int NUM_SLICES = 3,
  localparam int NSRC       = NUM_SLICES * SLICE_W,
  localparam int IDX_W      = $clog2(NSRC),
  localparam int BIT_W      = $clog2(SLICE_W),
  localparam int MOD_W      = ADDR_W - MOD_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [SLICE_W-1:0] rd_data,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              pend_valid_o,
  output logic [IDX_W-1:0]  pend_idx_o
);
  localparam logic [SLICE_W-1:0] CASC_MASK =
    SLICE_W'(3) | (SLICE_W'(3) << (SLICE_W - 2));
  localparam logic [MOD_W-1:0] SW_MOD = MOD_W'(NUM_SLICES);

  // ---- address decode ----
  logic [MOD_W-1:0] wr_mod, rd_mod;
  reg_sel_e         wr_sel, rd_sel;
  logic             wr_ok, rd_ok;

  assign wr_mod = wr_addr[ADDR_W-1:MOD_SHIFT];
  assign rd_mod = rd_addr[ADDR_W-1:MOD_SHIFT];
  assign wr_sel = reg_sel_e'(wr_addr[REG_LSB+REG_AW-1:REG_LSB]);
  assign rd_sel = reg_sel_e'(rd_addr[REG_LSB+REG_AW-1:REG_LSB]);
  assign wr_ok  = wr_en && (wr_addr[REG_LSB-1:0] == '0) &&
                  (wr_addr[MOD_SHIFT-1:REG_LSB+REG_AW] == '0);
  assign rd_ok  = (rd_addr[REG_LSB-1:0] == '0) &&
                  (rd_addr[MOD_SHIFT-1:REG_LSB+REG_AW] == '0);

  // ---- software interrupt word ----
  logic sw_q;
  always_ff @(posedge clk) begin
    if (rst) sw_q <= 1'b0;
    else if (wr_ok && wr_mod == SW_MOD && wr_sel == OFF_EN) sw_q <= wr_data[0];
  end

  // ---- input synchronisation ----
  logic [NSRC-1:0] src_s, src_x;
  vic_sync #(.W(NSRC), .STAGES(SYNC_LEN)) u_sync (
    .clk (clk), .rst (rst), .d (src_i), .q (src_s)
  );
  assign src_x = src_s | (NSRC'(sw_q) << SW_SRC);

  // ---- slices ----
  logic [SLICE_W-1:0] slice_in [NUM_SLICES];
  logic [SLICE_W-1:0] rd_word  [NUM_SLICES];
  logic [SLICE_W-1:0] cand_w   [NUM_SLICES];
  logic               irq_w    [NUM_SLICES];
  logic               fiq_w    [NUM_SLICES];
  logic               hit_w    [NUM_SLICES];
  logic [BIT_W-1:0]   bit_w    [NUM_SLICES];
  logic [SLICE_W-1:0] casc_vec;

  always_comb begin
    casc_vec              = '0;
    casc_vec[0]           = irq_w[1];
    casc_vec[1]           = irq_w[2];
    casc_vec[SLICE_W-2]   = fiq_w[1];
    casc_vec[SLICE_W-1]   = fiq_w[2];
  end

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    localparam logic [SLICE_W-1:0] FIXED = (g == 0) ? CASC_MASK : '0;
    logic [SLICE_W-1:0] search_vec;

    if (g == 0) begin : g_main
      assign slice_in[g] = (src_x[SLICE_W-1:0] & ~CASC_MASK) | casc_vec;
    end else begin : g_sub
      assign slice_in[g] = src_x[g*SLICE_W +: SLICE_W];
    end

    vic_slice #(.W(SLICE_W), .RST_EN(FIXED), .BYPASS(FIXED)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .src_i   (slice_in[g]),
      .wr_en   (wr_ok && wr_mod == MOD_W'(g)),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_word[g]),
      .cand_o  (cand_w[g]),
      .irq_o   (irq_w[g]),
      .fiq_o   (fiq_w[g])
    );

    assign search_vec = cand_w[g] & ~FIXED;

    vic_prio_find #(.W(SLICE_W)) u_find (
      .vec   (search_vec),
      .found (hit_w[g]),
      .idx   (bit_w[g])
    );
  end

  assign irq_o = irq_w[0];
  assign fiq_o = fiq_w[0];

  // ---- slice-order pending selection ----
  logic             pv_nxt;
  logic [IDX_W-1:0] pi_nxt;
  always_comb begin
    pv_nxt = 1'b0;
    pi_nxt = '0;
    for (int g = NUM_SLICES - 1; g >= 0; g--) begin
      if (hit_w[g]) begin
        pv_nxt = 1'b1;
        pi_nxt = IDX_W'(g * SLICE_W) + IDX_W'(bit_w[g]);
      end
    end
  end

  // ---- read mux ----
  logic [SLICE_W-1:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    if (rd_ok) begin
      if (rd_mod == SW_MOD) begin
        if (rd_sel == OFF_EN) rd_nxt = SLICE_W'(sw_q);
      end else begin
        for (int g = 0; g < NUM_SLICES; g++)
          if (rd_mod == MOD_W'(g)) rd_nxt = rd_word[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid_o <= 1'b0;
      pend_idx_o   <= '0;
      rd_data      <= '0;
    end else begin
      pend_valid_o <= pv_nxt;
      pend_idx_o   <= pi_nxt;
      rd_data      <= rd_nxt;
    end
  end
endmodule

// File: rtl/vic_cascade_chk.sv
module vic_cascade_chk #(
  parameter int SLICE_W = 32,
  parameter int NSRC    = 96,
  parameter int IDX_W   = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               pend_valid_o,
  input logic [IDX_W-1:0]   pend_idx_o,
  input logic [SLICE_W-1:0] rd_data
);
  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_o && !fiq_o && !pend_valid_o && rd_data == '0));

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (rst)
    pend_valid_o |-> (int'(pend_idx_o) < NSRC));

  assert_idle_idx_R8: assert property (@(posedge clk) disable iff (rst)
    !pend_valid_o |-> (pend_idx_o == '0));

  assert_casc_skip_R7: assert property (@(posedge clk) disable iff (rst)
    pend_valid_o |-> (int'(pend_idx_o) != 0 && int'(pend_idx_o) != 1 &&
                      int'(pend_idx_o) != SLICE_W - 2 &&
                      int'(pend_idx_o) != SLICE_W - 1));
endmodule

bind vic_cascade_top vic_cascade_chk #(
  .SLICE_W (SLICE_W),
  .NSRC    (NSRC),
  .IDX_W   (IDX_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .pend_valid_o (pend_valid_o),
  .pend_idx_o   (pend_idx_o),
  .rd_data      (rd_data)
);

// File: tb/vic_cascade_top_test.sv
`timescale 1ns/1ps
module vic_cascade_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o, fiq_o, pend_valid_o;
  logic [6:0]  pend_idx_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  vic_cascade_top uut (
    .clk (clk), .rst (rst), .src_i (src_i),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data),
    .irq_o (irq_o), .fiq_o (fiq_o),
    .pend_valid_o (pend_valid_o), .pend_idx_o (pend_idx_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: all requirements, actual=%0d cycles expected<50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {sub-B sources, sub-B enable, expected valid, expected index}
  localparam logic [71:0] VEC [7] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 7'd0},
    {32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 7'd64},
    {32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 7'd95},
    {32'h8000_0001, 32'h7FFF_FFFF, 1'b1, 7'd64},
    {32'h00F0_F000, 32'h00FF_FFFF, 1'b1, 7'd87},
    {32'h00F0_F000, 32'h000F_FFFF, 1'b1, 7'd79},
    {32'h1234_5678, 32'h0000_0000, 1'b0, 7'd0}
  };

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk("R2 irq after reset", 32'(irq_o), 32'd0);
    chk("R2 fiq after reset", 32'(fiq_o), 32'd0);
    chk("R2 pend after reset", 32'(pend_valid_o), 32'd0);
    rd(16'h0000, d); chk("R2 R1 main enable reset", d, 32'hC000_0003);
    rd(16'h4000, d); chk("R2 sub-A enable reset", d, 32'h0);
    rd(16'h0014, d); chk("R2 main route reset", d, 32'h0);

    // setup: subordinate slices active-high
    wr(16'h400C, 32'hFFFF_FFFF);
    wr(16'h800C, 32'hFFFF_FFFF);

    // R8 R6 vector walk over sub-B
    foreach (VEC[i]) begin
      src_i[95:64] = VEC[i][71:40];
      wr(16'h8000, VEC[i][39:8]);
      idle(10);
      chk("R8 pend valid", 32'(pend_valid_o), 32'(VEC[i][7]));
      chk("R8 pend index", 32'(pend_idx_o), 32'(VEC[i][6:0]));
      chk("R6 R7 irq via cascade", 32'(irq_o), 32'(VEC[i][7]));
    end

    // R5 raw visible while disabled
    src_i[95:64] = 32'h0000_0010;
    wr(16'h8000, 32'h0);
    idle(8);
    rd(16'h8004, d); chk("R5 raw shows disabled", d, 32'h0000_0010);
    rd(16'h8008, d); chk("R5 enabled status masked", d, 32'h0);
    // R10 enabled status not writable
    wr(16'h8008, 32'hFFFF_FFFF);
    rd(16'h8008, d); chk("R10 status write ignored", d, 32'h0);
    rd(16'h8000, d); chk("R10 enable untouched", d, 32'h0);
    src_i[95:64] = '0;

    // R7 cascade bits ignore external lines and polarity
    src_i[31:0] = 32'hC000_0003;
    idle(8);
    rd(16'h0004, d); chk("R7 main raw idle", d, 32'h3FFF_FFFC);
    src_i[31:0] = '0;

    // R6 R7 fast routing through sub-B
    wr(16'h8000, 32'h8);
    wr(16'h8014, 32'h8);
    wr(16'h0014, 32'h8000_0000);
    src_i[67] = 1'b1;
    idle(12);
    chk("R6 fiq asserted", 32'(fiq_o), 32'd1);
    chk("R6 irq quiet", 32'(irq_o), 32'd0);
    chk("R8 fast source not searched", 32'(pend_valid_o), 32'd0);
    rd(16'h0004, d); chk("R7 sub-B fast on bit31", d, 32'hBFFF_FFFC);
    wr(16'h0014, 32'h0);
    idle(6);
    chk("R6 irq after reroute", 32'(irq_o), 32'd1);
    chk("R6 fiq after reroute", 32'(fiq_o), 32'd0);
    wr(16'h8014, 32'h0);
    idle(10);
    chk("R8 sub-B normal source", 32'(pend_idx_o), 32'd67);
    rd(16'h0004, d); chk("R7 sub-B normal on bit1", d, 32'h3FFF_FFFE);
    // R8 main searched before subordinate (main bit5 active-low, input 0)
    wr(16'h0000, 32'hC000_0023);
    idle(6);
    chk("R8 main wins", 32'(pend_idx_o), 32'd5);
    chk("R8 irq held", 32'(irq_o), 32'd1);
    wr(16'h0000, 32'hC000_0003);
    src_i[67] = 1'b0;
    wr(16'h8000, 32'h0);
    idle(10);
    chk("R8 back to idle", 32'(pend_valid_o), 32'd0);

    // R3 level polarity
    wr(16'h400C, 32'hFFFF_FFDF);
    idle(8);
    rd(16'h4004, d); chk("R3 active-low idle input", d, 32'h0000_0020);
    src_i[37] = 1'b1;
    idle(8);
    rd(16'h4004, d); chk("R3 active-low driven high", d, 32'h0);
    src_i[37] = 1'b0;
    wr(16'h400C, 32'hFFFF_FFFF);

    // R4 edge capture and clear
    wr(16'h4010, 32'h0000_0080);
    @(negedge clk); src_i[39] = 1'b1;
    idle(2);        src_i[39] = 1'b0;
    idle(8);
    rd(16'h4004, d); chk("R4 rising edge latched", d, 32'h0000_0080);
    wr(16'h4004, 32'h0);
    rd(16'h4004, d); chk("R4 write 0 keeps latch", d, 32'h0000_0080);
    wr(16'h4004, 32'h0000_0080);
    rd(16'h4004, d); chk("R4 write 1 clears", d, 32'h0);
    wr(16'h400C, 32'hFFFF_FF7F);
    src_i[39] = 1'b1;
    idle(8);
    rd(16'h4004, d); chk("R4 rising ignored when falling", d, 32'h0);
    src_i[39] = 1'b0;
    idle(8);
    rd(16'h4004, d); chk("R4 falling edge latched", d, 32'h0000_0080);
    wr(16'h4004, 32'h0000_0080);
    wr(16'h400C, 32'hFFFF_FFFF);
    wr(16'h4010, 32'h0);

    // R9 software source 33
    wr(16'hC000, 32'h1);
    rd(16'hC000, d); chk("R9 readback", d, 32'h1);
    wr(16'h4000, 32'h2);
    idle(10);
    chk("R9 raised valid", 32'(pend_valid_o), 32'd1);
    chk("R9 raised index", 32'(pend_idx_o), 32'd33);
    // R1 misaligned write ignored
    wr(16'h4001, 32'hFFFF_FFFF);
    rd(16'h4000, d); chk("R1 misaligned ignored", d, 32'h2);
    wr(16'hC000, 32'h0);
    idle(10);
    chk("R9 cleared", 32'(pend_valid_o), 32'd0);
    chk("R9 irq cleared", 32'(irq_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule